// File: doc/BRIEF.md
# Snooping Transaction Output Queue

This block is the short transmit queue between an attraction-memory controller and a shared split-transaction bus. The controller pushes outgoing transactions into it. Each transaction has a kind code, an item identifier and a data word. The queue offers its oldest transaction to the bus arbiter and drops that transaction when the arbiter grants it.

While its entries wait, the queue watches every transaction the bus carries. When another node wins the bus with an Erase for some item, the queue drops every pending entry that targets that item, wherever the entry sits. The entries that remain close up and keep their order. The queue then tells the controller which slots were dropped and for which item, so the controller can move that item to its next state without resending its own Erase.

Top module: `obuf_snoop_queue`

## Requirements
- R1: After reset the queue is empty: `head_valid` is low, `enq_ready` is high and `purge_mask` is zero.
- R2: Entries leave in arrival order. `head_*` shows the oldest entry. When `bus_grant` is high while `head_valid` is high, the oldest entry is removed, and the next entry appears on `head_*` after the following clock edge.
- R3: The queue holds at most DEPTH (default 3) entries. `enq_ready` is low exactly when DEPTH entries are held. An `enq_valid` pulse while `enq_ready` is low leaves the queue unchanged.
- R4: A snooped foreign Erase removes every held entry whose item equals `snp_item`, in any slot. A foreign Erase is `snp_valid` high, `snp_kind` = 3'd1 and `snp_own` low.
- R5: After a removal the surviving entries close up without gaps and keep their relative order. An entry accepted in the same cycle is placed behind all survivors.
- R6: One cycle after a purge, `purge_mask` bit i is set for each removed slot i and `purge_item` carries the snooped item. Slot 0 is the oldest entry at the snoop cycle. `purge_mask` is zero in every other cycle.
- R7: A snooped transaction with `snp_own` high, or with any kind other than 3'd1, removes nothing.
- R8: If the oldest entry is granted in the same cycle that a foreign Erase matches it, the grant wins. The entry leaves as granted and `purge_mask` bit 0 stays low.
- R9: An entry accepted in the same cycle as a matching foreign Erase is not compared against that Erase and stays in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Controller offers a transaction |
| enq_kind | input | 3 | Kind code of the offered transaction |
| enq_item | input | ITEM_W | Item identifier of the offered transaction |
| enq_data | input | DATA_W | Data word of the offered transaction |
| enq_ready | output | 1 | Queue can accept a transaction |
| head_valid | output | 1 | Oldest entry is presented to the arbiter |
| head_kind | output | 3 | Kind code of the oldest entry |
| head_item | output | ITEM_W | Item identifier of the oldest entry |
| head_data | output | DATA_W | Data word of the oldest entry |
| bus_grant | input | 1 | Arbiter takes the oldest entry this cycle |
| snp_valid | input | 1 | A transaction is on the bus this cycle |
| snp_kind | input | 3 | Kind code of the bus transaction |
| snp_item | input | ITEM_W | Item identifier of the bus transaction |
| snp_own | input | 1 | Bus transaction was issued by this node |
| purge_mask | output | DEPTH | Per-slot strobe of entries removed by a snoop |
| purge_item | output | ITEM_W | Item identifier that caused the removal |

## Verification
Every result of this queue comes from a register, so each one is due exactly one clock edge after the stimulus that causes it. This holds for the new head after a grant, the changed ready level after an accept or removal, and the purge strobe and its item after a foreign Erase. The bench applies each cycle's inputs after a falling edge and updates its queue model with those same inputs. It then compares all outputs at the next falling edge, so every check falls in the one cycle where the result is due. Directed sequences cover purges in every slot, the grant-versus-purge collision, same-cycle accept and snoop, and pushes into a full queue. A long random run with a small item space then forces frequent matches.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    TK_NONE   = 3'd0,
    TK_ERASE  = 3'd1,
    TK_EXCL   = 3'd2,
    TK_READ   = 3'd3,
    TK_DATA   = 3'd4,
    TK_INJECT = 3'd5,
    TK_OUT    = 3'd6
  } txn_kind_e;
endpackage

// File: rtl/obuf_item_match.sv
module obuf_item_match
  import obuf_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int ITEM_W = 20
) (
  input  logic [DEPTH-1:0]        slot_valid,
  input  logic [DEPTH*ITEM_W-1:0] slot_items,
  input  logic                    snp_valid,
  input  logic [KIND_W-1:0]       snp_kind,
  input  logic [ITEM_W-1:0]       snp_item,
  input  logic                    snp_own,
  output logic [DEPTH-1:0]        hit
);
  logic foreign_erase;

  assign foreign_erase = snp_valid && !snp_own && (snp_kind == TK_ERASE);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = foreign_erase && slot_valid[i] &&
                    (slot_items[i*ITEM_W +: ITEM_W] == snp_item);
  end
endmodule

// File: rtl/obuf_compact.sv
module obuf_compact #(
  parameter int DEPTH = 3,
  parameter int ENT_W = 55
) (
  input  logic [DEPTH*ENT_W-1:0] cur_slots,
  input  logic [DEPTH-1:0]       keep,
  input  logic                   push,
  input  logic [ENT_W-1:0]       push_ent,
  output logic [DEPTH*ENT_W-1:0] nxt_slots,
  output logic [DEPTH-1:0]       nxt_valid
);
  always_comb begin
    int pos;
    nxt_slots = '0;
    nxt_valid = '0;
    pos       = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (keep[i]) begin
        nxt_slots[pos*ENT_W +: ENT_W] = cur_slots[i*ENT_W +: ENT_W];
        nxt_valid[pos]                = 1'b1;
        pos                           = pos + 1;
      end
    end
    if (push && (pos < DEPTH)) begin
      nxt_slots[pos*ENT_W +: ENT_W] = push_ent;
      nxt_valid[pos]                = 1'b1;
    end
  end
endmodule

// File: rtl/obuf_snoop_queue.sv
module obuf_snoop_queue
  import obuf_pkg::*;
#(
  parameter int DEPTH  = 3,
  parameter int ITEM_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [2:0]        enq_kind,
  input  logic [ITEM_W-1:0] enq_item,
  input  logic [DATA_W-1:0] enq_data,
  output logic              enq_ready,
  output logic              head_valid,
  output logic [2:0]        head_kind,
  output logic [ITEM_W-1:0] head_item,
  output logic [DATA_W-1:0] head_data,
  input  logic              bus_grant,
  input  logic              snp_valid,
  input  logic [2:0]        snp_kind,
  input  logic [ITEM_W-1:0] snp_item,
  input  logic              snp_own,
  output logic [DEPTH-1:0]  purge_mask,
  output logic [ITEM_W-1:0] purge_item
);
  localparam int ENT_W    = KIND_W + ITEM_W + DATA_W;
  localparam int ITEM_LSB = DATA_W;
  localparam int KIND_LSB = DATA_W + ITEM_W;

  logic [DEPTH*ENT_W-1:0]  slots_q, slots_d;
  logic [DEPTH-1:0]        valid_q, valid_d;
  logic [DEPTH-1:0]        purge_mask_q;
  logic [ITEM_W-1:0]       purge_item_q;
  logic [DEPTH*ITEM_W-1:0] slot_items;
  logic [DEPTH-1:0]        match_hit, purge_hit, take_mask, keep;
  logic                    head_take, enq_fire, load_en;
  logic [ENT_W-1:0]        push_ent;

  for (genvar i = 0; i < DEPTH; i++) begin : g_items
    assign slot_items[i*ITEM_W +: ITEM_W] = slots_q[i*ENT_W + ITEM_LSB +: ITEM_W];
  end

  assign enq_ready  = !valid_q[DEPTH-1];
  assign head_valid = valid_q[0];
  assign head_kind  = slots_q[KIND_LSB +: KIND_W];
  assign head_item  = slots_q[ITEM_LSB +: ITEM_W];
  assign head_data  = slots_q[0 +: DATA_W];
  assign purge_mask = purge_mask_q;
  assign purge_item = purge_item_q;

  assign head_take = bus_grant && valid_q[0];
  assign enq_fire  = enq_valid && enq_ready;
  assign push_ent  = {enq_kind, enq_item, enq_data};

  obuf_item_match #(.DEPTH(DEPTH), .ITEM_W(ITEM_W)) u_match (
    .slot_valid (valid_q),
    .slot_items (slot_items),
    .snp_valid  (snp_valid),
    .snp_kind   (snp_kind),
    .snp_item   (snp_item),
    .snp_own    (snp_own),
    .hit        (match_hit)
  );

  // Grant has priority over purge for the oldest entry.
  always_comb begin
    take_mask    = '0;
    take_mask[0] = head_take;
    purge_hit    = match_hit & ~take_mask;
    keep         = valid_q & ~purge_hit & ~take_mask;
    load_en      = head_take || (|purge_hit) || enq_fire;
  end

  obuf_compact #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_compact (
    .cur_slots (slots_q),
    .keep      (keep),
    .push      (enq_fire),
    .push_ent  (push_ent),
    .nxt_slots (slots_d),
    .nxt_valid (valid_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots_q      <= '0;
      valid_q      <= '0;
      purge_mask_q <= '0;
      purge_item_q <= '0;
    end else begin
      if (load_en) begin
        slots_q <= slots_d;
        valid_q <= valid_d;
      end
      purge_mask_q <= purge_hit;
      if (|purge_hit) begin
        purge_item_q <= snp_item;
      end
    end
  end

  // R5: occupied slots always form a gap-free run from slot 0
  for (genvar i = 1; i < DEPTH; i++) begin : g_contig
    a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[i] |-> valid_q[i-1]);
  end

  // R6: reported item equals the snooped item of the previous cycle
  a_r6_purge_item: assert property (@(posedge clk) disable iff (!rst_n)
    (|purge_mask) |-> (purge_item == $past(snp_item)));

  // R7: strobes only follow a foreign Erase
  a_r7_foreign_only: assert property (@(posedge clk) disable iff (!rst_n)
    (|purge_mask) |-> $past(snp_valid && !snp_own && (snp_kind == TK_ERASE)));

  // R8: a granted head never shows up as purged
  a_r8_grant_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_grant && head_valid) |-> !purge_mask[0]);

  // R2: an untouched head holds its contents
  a_r2_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (head_valid && !bus_grant &&
     !(snp_valid && !snp_own && (snp_kind == TK_ERASE) && (snp_item == head_item)))
    |=> (head_valid && $stable(head_item) && $stable(head_kind) && $stable(head_data)));

  // R3/R4: occupancy balances accepts, grants and purges
  a_r4_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(valid_q) + $countones(purge_mask)) ==
    ($past($countones(valid_q)) + $past(int'(enq_fire)) - $past(int'(head_take))));
endmodule

// File: tb/obuf_snoop_queue_test.sv
module obuf_snoop_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 3;
  localparam int ITEM_W = 20;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              enq_valid;
  logic [2:0]        enq_kind;
  logic [ITEM_W-1:0] enq_item;
  logic [DATA_W-1:0] enq_data;
  logic              enq_ready;
  logic              head_valid;
  logic [2:0]        head_kind;
  logic [ITEM_W-1:0] head_item;
  logic [DATA_W-1:0] head_data;
  logic              bus_grant;
  logic              snp_valid;
  logic [2:0]        snp_kind;
  logic [ITEM_W-1:0] snp_item;
  logic              snp_own;
  logic [DEPTH-1:0]  purge_mask;
  logic [ITEM_W-1:0] purge_item;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [2:0]        k;
    logic [ITEM_W-1:0] it;
    logic [DATA_W-1:0] d;
  } ent_t;

  ent_t              mq[$];
  logic [DEPTH-1:0]  exp_mask;
  logic [ITEM_W-1:0] exp_pitem;

  always #(CLK_PERIOD/2) clk = ~clk;

  obuf_snoop_queue #(.DEPTH(DEPTH), .ITEM_W(ITEM_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_item(enq_item), .enq_data(enq_data),
    .enq_ready(enq_ready),
    .head_valid(head_valid), .head_kind(head_kind), .head_item(head_item), .head_data(head_data),
    .bus_grant(bus_grant),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_item(snp_item), .snp_own(snp_own),
    .purge_mask(purge_mask), .purge_item(purge_item)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string ptag);
    check("R2 head_valid", 64'(head_valid), 64'(mq.size() > 0));
    if (mq.size() > 0) begin
      check("R2 head_kind", 64'(head_kind), 64'(mq[0].k));
      check("R2/R5 head_item", 64'(head_item), 64'(mq[0].it));
      check("R2 head_data", 64'(head_data), 64'(mq[0].d));
    end
    check("R3 enq_ready", 64'(enq_ready), 64'(mq.size() < DEPTH));
    check({ptag, " purge_mask"}, 64'(purge_mask), 64'(exp_mask));
    if (exp_mask != 0) check("R6 purge_item", 64'(purge_item), 64'(exp_pitem));
  endtask

  task automatic step(input logic ev, input logic [2:0] ek, input logic [ITEM_W-1:0] ei,
                      input logic [DATA_W-1:0] ed, input logic gr,
                      input logic sv, input logic [2:0] sk, input logic [ITEM_W-1:0] si,
                      input logic so, input string ptag);
    ent_t nq[$];
    logic fire, take;
    enq_valid = ev; enq_kind = ek; enq_item = ei; enq_data = ed;
    bus_grant = gr; snp_valid = sv; snp_kind = sk; snp_item = si; snp_own = so;
    fire = ev && (mq.size() < DEPTH);
    take = gr && (mq.size() > 0);
    exp_mask = '0;
    for (int i = 0; i < mq.size(); i++) begin
      if (i == 0 && take) continue;
      if (sv && !so && sk == 3'd1 && mq[i].it == si) exp_mask[i] = 1'b1;
      else nq.push_back(mq[i]);
    end
    if (fire) nq.push_back('{ek, ei, ed});
    if (exp_mask != 0) exp_pitem = si;
    mq = nq;
    @(posedge clk);
    @(negedge clk);
    compare_all(ptag);
  endtask

  task automatic push(input logic [2:0] k, input logic [ITEM_W-1:0] it, input logic [DATA_W-1:0] d);
    step(1, k, it, d, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic erase(input logic [ITEM_W-1:0] it, input string ptag);
    step(0, 0, 0, 0, 0, 1, 3'd1, it, 0, ptag);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(0, 0, 0, 0, 1, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    enq_valid = 0; enq_kind = 0; enq_item = 0; enq_data = 0;
    bus_grant = 0; snp_valid = 0; snp_kind = 0; snp_item = 0; snp_own = 0;
    exp_mask = '0; exp_pitem = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 head_valid", 64'(head_valid), 64'd0);
    check("R1 enq_ready", 64'(enq_ready), 64'd1);
    check("R1 purge_mask", 64'(purge_mask), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3: fill, overfill ignored, drain in order
    push(3'd3, 20'h10, 32'hA0);
    push(3'd1, 20'h11, 32'hA1);
    push(3'd4, 20'h12, 32'hA2);
    push(3'd5, 20'h13, 32'hA3);   // R3: ignored while full
    drain();

    // R4/R5/R6: purge first and last slot, middle survives
    push(3'd3, 20'h20, 32'hB0);
    push(3'd3, 20'h21, 32'hB1);
    push(3'd1, 20'h20, 32'hB2);
    erase(20'h20, "R4/R6");
    drain();

    // R4: purge middle only
    push(3'd3, 20'h30, 32'hC0);
    push(3'd3, 20'h31, 32'hC1);
    push(3'd3, 20'h32, 32'hC2);
    erase(20'h31, "R4/R5");
    // R7: own erase and non-erase kinds do nothing
    step(0, 0, 0, 0, 0, 1, 3'd1, 20'h30, 1, "R7");
    step(0, 0, 0, 0, 0, 1, 3'd3, 20'h30, 0, "R7");
    step(0, 0, 0, 0, 0, 1, 3'd2, 20'h32, 0, "R7");
    // R8: grant and purge on the head in one cycle
    step(0, 0, 0, 0, 1, 1, 3'd1, 20'h30, 0, "R8");
    drain();

    // R9/R5: push same item as a foreign erase in the same cycle
    push(3'd3, 20'h40, 32'hD0);
    push(3'd3, 20'h41, 32'hD1);
    step(1, 3'd1, 20'h40, 32'hD2, 0, 1, 3'd1, 20'h40, 0, "R9");
    drain();

    // random run with a narrow item space
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 1), 3'($urandom_range(0, 6)), 20'($urandom_range(0, 3)),
           $urandom, ($urandom_range(0, 2) == 0), $urandom_range(0, 1),
           3'($urandom_range(0, 2)), 20'($urandom_range(0, 3)),
           ($urandom_range(0, 3) == 0), "R4/R6/R7/R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule